// File: doc/BRIEF.md
# Programmable almost-empty / almost-full flag unit

This block is the flag-generation logic that sits beside a dual-clock FIFO memory. It tracks how many words the FIFO holds and produces three active-low status outputs from that count: almost-empty, almost-full and half-full. Occupancy is counted on the write clock and on the read clock by increment strobes taken from the FIFO's own enables. Each clock domain sees the other domain's count through a Gray-coded synchronizer. The memory array is outside this block.

The almost-empty and almost-full thresholds are held in two offset registers. A master reset loads both offsets with one of eight preset values, picked by two select pins and the load pin. After reset, software can overwrite the offsets in parallel from the write data bus or serially from a one-bit input, and can read both back on the read data bus. A mode pin sampled at reset chooses how the two programmable flags are timed. In synchronous timing each flag is a register on its own clock. In asynchronous timing each flag is set by the clock that moves it toward its threshold and cleared by the opposite clock, with no synchronizer delay. A second pin sampled at reset says whether bit 8 of the data bus is a parity bit during parallel loads.

Top module: `progFlagUnit`

## Requirements
- R1: While `mrstN` is low (sampled on each clock), the block sets `aeN`=0, `afN`=1, `hfN`=1 and `dOut`=0. It loads both offsets with 2^(i+3)-1, where i = {`ldN`,`offSel[1]`,`offSel[0]`} read as a 3-bit number (so 7 up to 1023).
- R2: A rising `wrClk` edge with `wenN`=0 and `ldN`=1 adds one word, unless the write side sees DEPTH (1024) words. A rising `rdClk` edge with `renN`=0 and `ldN`=1 removes one word, unless the read side sees zero words. Occupancy never leaves the range 0 to DEPTH.
- R3: A rising `wrClk` edge with `wenN`=0 and `ldN`=0 loads one offset from `dIn` and does not change occupancy. Successive parallel loads alternate between the targets, empty offset first and then full offset.
- R4: A rising `wrClk` edge with `senN`=0, `ldN`=0 and `wenN`=1 shifts `serIn` into one offset bit, least significant bit first. The first 10 bits fill the empty offset and the next 10 fill the full offset. The sequence restarts after 20 bits.
- R5: A rising `rdClk` edge with `renN`=0 and `ldN`=0 drives one offset onto `dOut[9:0]`, with zeros above. Successive read-backs alternate between the offsets, empty first. At any other `rdClk` edge, `dOut` holds its value.
- R6: If `paritySel` was 1 at reset, a parallel load takes its offset from {`dIn[17:9]`,`dIn[7:0]`} with bit 8 skipped. If `paritySel` was 0, the offset is `dIn[9:0]`. In both cases, bits that fall above the 10-bit offset are ignored.
- R7: `aeN` is low exactly when occupancy is less than or equal to the empty offset.
- R8: `afN` is low exactly when free space (DEPTH minus occupancy) is less than or equal to the full offset.
- R9: `hfN` is a `wrClk` register. It goes low one edge after the write-side occupancy exceeds DEPTH/2 (512).
- R10: In synchronous timing, `aeN` is a `rdClk` register and `afN` is a `wrClk` register. With both clocks tied together, a write at edge k moves `aeN` at edge k+3, and a read at edge k moves `aeN` at edge k+1.
- R11: In asynchronous timing, the flags follow the raw counts directly. `aeN` falls right after the read edge that brings occupancy down to the empty offset and rises right after the write edge that lifts it above. `afN` falls right after the write edge and rises right after the read edge.
- R12: `asyncSel` and `paritySel` take effect only while `mrstN` is low. Changing them later has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wrClk | input | 1 | Write-side clock |
| rdClk | input | 1 | Read-side clock |
| mrstN | input | 1 | Master reset, active low, sampled on both clocks |
| asyncSel | input | 1 | Flag timing select at reset: 1 asynchronous, 0 synchronous |
| paritySel | input | 1 | At reset: 1 treats bit 8 as parity in parallel loads |
| offSel | input | 2 | Preset offset select, used with ldN during reset |
| wenN | input | 1 | Write enable, active low |
| senN | input | 1 | Serial load enable, active low |
| serIn | input | 1 | Serial offset bit |
| renN | input | 1 | Read enable, active low |
| ldN | input | 1 | Offset access select, active low; preset select bit at reset |
| dIn | input | 18 | Write data bus, used for parallel offset loads |
| dOut | output | 18 | Read data bus, carries offset read-back |
| aeN | output | 1 | Almost-empty flag, active low |
| afN | output | 1 | Almost-full flag, active low |
| hfN | output | 1 | Half-full flag, active low |

## Verification
The bench builds the block with its default parameters: a depth of 1024 words, 10-bit offsets and an 18-bit data bus. At that size the largest preset offset (1023) is reachable, and so are the full, half-full and almost-full boundaries, each within about a thousand cycles. The 18-bit bus is also wide enough for the parity gap at bit 8 and the ignored top bits to matter. Both clocks are driven from one source, so the synchronizer latency of the synchronous flags can be checked to the exact edge and compared with the zero-delay asynchronous timing.

// File: rtl/progFlagPkg.sv
`timescale 1ns/1ps
package progFlagPkg;

  // Per-edge actions decoded by the control module for the datapath
  typedef struct packed {
    logic wrInc;   // occupancy up (write domain)
    logic rdInc;   // occupancy down (read domain)
    logic ldPar;   // parallel offset load (write domain)
    logic ldSer;   // serial offset bit (write domain)
    logic rdBack;  // offset read-back (read domain)
  } flagStb_t;

  // Configuration captured while master reset is held
  typedef struct packed {
    logic asyncMode;
    logic ipMode;
  } flagCfg_t;

endpackage

// File: rtl/progFlagSync.sv
`timescale 1ns/1ps
module progFlagSync #(
  parameter int W      = 11,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stg <= '0;
    end else begin
      stg[0] <= din;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign dout = stg[STAGES-1];

endmodule

// File: rtl/progFlagCtrl.sv
`timescale 1ns/1ps
module progFlagCtrl
  import progFlagPkg::*;
(
  input  logic       wrClk,
  input  logic       rdClk,
  input  logic       mrstN,
  input  logic       asyncSel,
  input  logic       paritySel,
  input  logic [1:0] offSel,
  input  logic       ldN,
  input  logic       wenN,
  input  logic       senN,
  input  logic       renN,
  input  logic       isFullW,
  input  logic       isEmptyR,
  output logic [2:0] defIdx,
  output flagCfg_t   cfgW,
  output logic       asyncR,
  output flagStb_t   stb
);

  // preset index comes straight from the pins; used only during reset
  assign defIdx = {ldN, offSel};

  // configuration is captured only while reset is held
  always_ff @(posedge wrClk) begin
    if (!mrstN) begin
      cfgW.asyncMode <= asyncSel;
      cfgW.ipMode    <= paritySel;
    end
  end

  always_ff @(posedge rdClk) begin
    if (!mrstN) asyncR <= asyncSel;
  end

  always_comb begin
    stb.wrInc  = mrstN & ~wenN & ldN & ~isFullW;
    stb.ldPar  = mrstN & ~wenN & ~ldN;
    stb.ldSer  = mrstN & ~senN & ~ldN & wenN;   // parallel load wins
    stb.rdInc  = mrstN & ~renN & ldN & ~isEmptyR;
    stb.rdBack = mrstN & ~renN & ~ldN;
  end

endmodule

// File: rtl/progFlagDatapath.sv
`timescale 1ns/1ps
module progFlagDatapath
  import progFlagPkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 18
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              mrstN,
  input  flagStb_t          stb,
  input  flagCfg_t          cfgW,
  input  logic              asyncR,
  input  logic [2:0]        defIdx,
  input  logic              serIn,
  input  logic [DATA_W-1:0] dIn,
  output logic [DATA_W-1:0] dOut,
  output logic              aeN,
  output logic              afN,
  output logic              hfN,
  output logic              isFullW,
  output logic              isEmptyR,
  output logic [ADDR_W:0]   occRaw
);

  localparam int CNT_W   = ADDR_W + 1;
  localparam int OFF_W   = ADDR_W;
  localparam int SER_LEN = 2 * OFF_W;
  localparam int SERC_W  = $clog2(SER_LEN);
  localparam logic [CNT_W-1:0]  DEPTH_C = CNT_W'(1) << ADDR_W;
  localparam logic [CNT_W-1:0]  HALF_C  = DEPTH_C >> 1;
  localparam logic [OFF_W-1:0]  ONE_OFF = OFF_W'(1);
  localparam logic [SERC_W-1:0] SER_MID = SERC_W'(OFF_W);
  localparam logic [SERC_W-1:0] SER_END = SERC_W'(SER_LEN - 1);

  function automatic logic [CNT_W-1:0] toGray(input logic [CNT_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [CNT_W-1:0] fromGray(input logic [CNT_W-1:0] g);
    logic [CNT_W-1:0] b;
    b[CNT_W-1] = g[CNT_W-1];
    for (int i = CNT_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  function automatic logic [OFF_W-1:0] presetOffset(input logic [2:0] idx);
    logic [31:0] v;
    v = (32'd1 << (32'(idx) + 32'd3)) - 32'd1;
    return OFF_W'(v);
  endfunction

  // ---------------- write domain ----------------
  logic [CNT_W-1:0]  wrCnt, wrGray, rdGraySync, occW, freeW;
  logic [OFF_W-1:0]  emptyOff, fullOff, parOff;
  logic [SERC_W-1:0] serCnt;
  logic              wrSel, afSyncN;

  assign occW    = wrCnt - fromGray(rdGraySync);
  assign freeW   = DEPTH_C - occW;
  assign isFullW = (occW == DEPTH_C);

  // parity option: bit 8 skipped when interspersed parity is selected
  assign parOff = cfgW.ipMode ? OFF_W'({dIn[DATA_W-1:9], dIn[7:0]})
                              : dIn[OFF_W-1:0];

  always_ff @(posedge wrClk) begin
    if (!mrstN) begin
      wrCnt    <= '0;
      wrGray   <= '0;
      emptyOff <= presetOffset(defIdx);
      fullOff  <= presetOffset(defIdx);
      wrSel    <= 1'b0;
      serCnt   <= '0;
      afSyncN  <= 1'b1;
      hfN      <= 1'b1;
    end else begin
      if (stb.wrInc) begin
        wrCnt  <= wrCnt + CNT_W'(1);
        wrGray <= toGray(wrCnt + CNT_W'(1));
      end
      if (stb.ldPar) begin
        if (!wrSel) emptyOff <= parOff;
        else        fullOff  <= parOff;
        wrSel <= ~wrSel;
      end else if (stb.ldSer) begin
        if (serCnt < SER_MID)
          emptyOff <= (emptyOff & ~(ONE_OFF << serCnt))
                    | (OFF_W'(serIn) << serCnt);
        else
          fullOff  <= (fullOff & ~(ONE_OFF << (serCnt - SER_MID)))
                    | (OFF_W'(serIn) << (serCnt - SER_MID));
        serCnt <= (serCnt == SER_END) ? '0 : serCnt + SERC_W'(1);
      end
      hfN     <= ~(occW > HALF_C);
      afSyncN <= ~(freeW <= CNT_W'(fullOff));
    end
  end

  // ---------------- read domain ----------------
  logic [CNT_W-1:0] rdCnt, rdGray, wrGraySync, occR;
  logic             rdSel, aeSyncN;

  assign occR     = fromGray(wrGraySync) - rdCnt;
  assign isEmptyR = (occR == '0);

  always_ff @(posedge rdClk) begin
    if (!mrstN) begin
      rdCnt   <= '0;
      rdGray  <= '0;
      rdSel   <= 1'b0;
      dOut    <= '0;
      aeSyncN <= 1'b0;
    end else begin
      if (stb.rdInc) begin
        rdCnt  <= rdCnt + CNT_W'(1);
        rdGray <= toGray(rdCnt + CNT_W'(1));
      end
      if (stb.rdBack) begin
        dOut  <= DATA_W'(rdSel ? fullOff : emptyOff);
        rdSel <= ~rdSel;
      end
      aeSyncN <= ~(occR <= CNT_W'(emptyOff));
    end
  end

  // ---------------- crossings ----------------
  progFlagSync #(.W(CNT_W), .STAGES(2)) wrToRd_i (
    .clk(rdClk), .rstN(mrstN), .din(wrGray), .dout(wrGraySync));

  progFlagSync #(.W(CNT_W), .STAGES(2)) rdToWr_i (
    .clk(wrClk), .rstN(mrstN), .din(rdGray), .dout(rdGraySync));

  // ---------------- flag outputs ----------------
  logic [CNT_W-1:0] freeRaw;
  assign occRaw  = wrCnt - rdCnt;
  assign freeRaw = DEPTH_C - occRaw;

  assign aeN = asyncR         ? ~(occRaw  <= CNT_W'(emptyOff)) : aeSyncN;
  assign afN = cfgW.asyncMode ? ~(freeRaw <= CNT_W'(fullOff))  : afSyncN;

endmodule

// File: rtl/progFlagUnit.sv
`timescale 1ns/1ps
module progFlagUnit
  import progFlagPkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 18
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              mrstN,
  input  logic              asyncSel,
  input  logic              paritySel,
  input  logic [1:0]        offSel,
  input  logic              wenN,
  input  logic              senN,
  input  logic              serIn,
  input  logic              renN,
  input  logic              ldN,
  input  logic [DATA_W-1:0] dIn,
  output logic [DATA_W-1:0] dOut,
  output logic              aeN,
  output logic              afN,
  output logic              hfN
);

  flagStb_t        stb;
  flagCfg_t        cfgW;
  logic            asyncR, asyncW;
  logic [2:0]      defIdx;
  logic            isFullW, isEmptyR;
  logic [ADDR_W:0] occRaw;

  assign asyncW = cfgW.asyncMode;

  progFlagCtrl ctrl_i (
    .wrClk(wrClk), .rdClk(rdClk), .mrstN(mrstN),
    .asyncSel(asyncSel), .paritySel(paritySel), .offSel(offSel),
    .ldN(ldN), .wenN(wenN), .senN(senN), .renN(renN),
    .isFullW(isFullW), .isEmptyR(isEmptyR),
    .defIdx(defIdx), .cfgW(cfgW), .asyncR(asyncR), .stb(stb));

  progFlagDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dp_i (
    .wrClk(wrClk), .rdClk(rdClk), .mrstN(mrstN),
    .stb(stb), .cfgW(cfgW), .asyncR(asyncR), .defIdx(defIdx),
    .serIn(serIn), .dIn(dIn), .dOut(dOut),
    .aeN(aeN), .afN(afN), .hfN(hfN),
    .isFullW(isFullW), .isEmptyR(isEmptyR), .occRaw(occRaw));

endmodule

// File: rtl/progFlagUnitChecker.sv
`timescale 1ns/1ps
module progFlagUnitChecker #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 18
) (
  input logic              wrClk,
  input logic              rdClk,
  input logic              mrstN,
  input logic              renN,
  input logic              ldN,
  input logic [DATA_W-1:0] dOut,
  input logic              aeN,
  input logic              afN,
  input logic [ADDR_W:0]   occRaw,
  input logic              asyncW,
  input logic              asyncR
);

  localparam logic [ADDR_W:0] DEPTH_C = (ADDR_W + 1)'(1) << ADDR_W;

  // R2: occupancy stays within the memory size
  p_occ_bound_r2: assert property (@(posedge wrClk) disable iff (!mrstN)
    occRaw <= DEPTH_C);

  // R3: an offset access on the write side never moves occupancy
  p_load_no_count_r3: assert property (@(posedge wrClk) disable iff (!mrstN)
    (!ldN && renN) |=> $stable(occRaw));

  // R5: read data bus changes only on a read-back edge
  p_dout_hold_r5: assert property (@(posedge rdClk) disable iff (!mrstN)
    (renN || ldN) |=> $stable(dOut));

  // R11: asynchronous almost-empty is active whenever nothing is stored
  p_async_empty_r11: assert property (@(posedge rdClk) disable iff (!mrstN)
    (asyncR && occRaw == '0) |-> !aeN);

  // R11: asynchronous almost-full is active whenever the store is full
  p_async_full_r11: assert property (@(posedge wrClk) disable iff (!mrstN)
    (asyncW && occRaw == DEPTH_C) |-> !afN);

endmodule

bind progFlagUnit progFlagUnitChecker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .wrClk(wrClk), .rdClk(rdClk), .mrstN(mrstN), .renN(renN), .ldN(ldN),
  .dOut(dOut), .aeN(aeN), .afN(afN), .occRaw(occRaw),
  .asyncW(asyncW), .asyncR(asyncR));

// File: tb/progFlagUnit_tb_top.sv
`timescale 1ns/1ps
module progFlagUnit_tb_top;

  localparam int ADDR_W = 10;
  localparam int DATA_W = 18;
  localparam int OFF_W  = ADDR_W;

  logic clk = 1'b0;
  logic mrstN = 1'b0, asyncSel = 1'b0, paritySel = 1'b0;
  logic [1:0] offSel = 2'b00;
  logic wenN = 1'b1, senN = 1'b1, serIn = 1'b0, renN = 1'b1, ldN = 1'b1;
  logic [DATA_W-1:0] dIn = '0;
  logic [DATA_W-1:0] dOut;
  logic aeN, afN, hfN;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  progFlagUnit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
    .wrClk(clk), .rdClk(clk), .mrstN(mrstN), .asyncSel(asyncSel),
    .paritySel(paritySel), .offSel(offSel), .wenN(wenN), .senN(senN),
    .serIn(serIn), .renN(renN), .ldN(ldN), .dIn(dIn), .dOut(dOut),
    .aeN(aeN), .afN(afN), .hfN(hfN));

  task automatic check(input bit ok, input string tag, input int unsigned act,
                       input int unsigned exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ---------------- scoreboard for offset read-back ----------------
  int unsigned expQ[$];
  string       tagQ[$];
  logic        rbSeen = 1'b0;

  always @(posedge clk) rbSeen <= mrstN && !renN && !ldN;

  always @(negedge clk) begin
    if (rbSeen) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R5 unexpected read-back", dOut, 0);
      end else begin
        int unsigned e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(dOut == DATA_W'(e), t, dOut, e);
      end
    end
  end

  // ---------------- driver tasks ----------------
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset(input logic as, input logic ip, input logic ld,
                         input logic [1:0] sel);
    @(negedge clk);
    mrstN = 1'b0; asyncSel = as; paritySel = ip; ldN = ld; offSel = sel;
    wenN = 1'b1; senN = 1'b1; renN = 1'b1;
    idle(3);
    mrstN = 1'b1; ldN = 1'b1;
    idle(1);
  endtask

  task automatic writeN(input int n);
    wenN = 1'b0; ldN = 1'b1;
    idle(n);
    wenN = 1'b1;
  endtask

  task automatic readN(input int n);
    renN = 1'b0; ldN = 1'b1;
    idle(n);
    renN = 1'b1;
  endtask

  task automatic loadPar(input logic [DATA_W-1:0] d);
    wenN = 1'b0; ldN = 1'b0; dIn = d;
    idle(1);
    wenN = 1'b1; ldN = 1'b1;
  endtask

  task automatic loadSer(input int unsigned e, input int unsigned f);
    senN = 1'b0; ldN = 1'b0;
    for (int i = 0; i < 2 * OFF_W; i++) begin
      serIn = (i < OFF_W) ? e[i] : f[i - OFF_W];
      idle(1);
    end
    senN = 1'b1; ldN = 1'b1;
  endtask

  task automatic readBack(input int unsigned exp, input string tag);
    expQ.push_back(exp);
    tagQ.push_back(tag);
    renN = 1'b0; ldN = 1'b0;
    idle(1);
    renN = 1'b1; ldN = 1'b1;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog all-requirements actual=timeout expected=finish");
    finishRun();
  end

  // ---------------- stimulus ----------------
  initial begin
    // synchronous timing, no parity, preset index 2 -> 31
    doReset(1'b0, 1'b0, 1'b0, 2'b10);
    check(aeN == 1'b0, "R1 aeN after reset", aeN, 0);
    check(afN == 1'b1, "R1 afN after reset", afN, 1);
    check(hfN == 1'b1, "R1 hfN after reset", hfN, 1);
    check(dOut == '0,  "R1 dOut after reset", dOut, 0);
    readBack(31, "R1 preset empty offset");
    readBack(31, "R1 preset full offset");

    // R12: mode pins after reset are ignored, timing stays synchronous
    asyncSel = 1'b1; paritySel = 1'b1;
    writeN(31);
    idle(6);
    check(aeN == 1'b0, "R7 occupancy equal to empty offset", aeN, 0);
    writeN(1);
    check(aeN == 1'b0, "R10 aeN right after write edge", aeN, 0);
    idle(2);
    check(aeN == 1'b0, "R10 aeN two edges after write", aeN, 0);
    idle(1);
    check(aeN == 1'b1, "R10 R12 aeN three edges after write", aeN, 1);
    check(dOut == DATA_W'(31), "R5 dOut held during writes", dOut, 31);

    // half-full boundary
    writeN(480);
    idle(4);
    check(hfN == 1'b1, "R9 occupancy exactly half", hfN, 1);
    writeN(1);
    check(hfN == 1'b1, "R9 hfN at write edge", hfN, 1);
    idle(1);
    check(hfN == 1'b0, "R9 hfN one edge later", hfN, 0);

    // almost-full boundary with preset 31
    writeN(479);
    idle(4);
    check(afN == 1'b1, "R8 free space 32", afN, 1);
    writeN(1);
    check(afN == 1'b1, "R8 afN at write edge", afN, 1);
    idle(1);
    check(afN == 1'b0, "R8 R10 free space 31", afN, 0);

    // fill and overrun: extra writes must be dropped
    writeN(36);
    idle(4);
    check(afN == 1'b0, "R8 full", afN, 0);
    readN(992);
    idle(6);
    check(aeN == 1'b1, "R2 R7 occupancy 32 after overrun", aeN, 1);
    check(afN == 1'b1, "R8 free space 992", afN, 1);
    readN(1);
    check(aeN == 1'b1, "R10 aeN at read edge", aeN, 1);
    idle(1);
    check(aeN == 1'b0, "R7 R10 aeN one edge after read", aeN, 0);

    // drain and underrun: extra reads must be dropped
    readN(31);
    readN(5);
    idle(6);
    writeN(32);
    idle(6);
    check(aeN == 1'b1, "R2 occupancy 32 after underrun", aeN, 1);

    // parallel load, no parity: top bits ignored, bit 8 is data
    loadPar(18'h30000 | 18'd100);
    loadPar(18'd900);
    readBack(100, "R3 R6 parallel empty offset");
    readBack(900, "R3 R6 parallel full offset");
    idle(6);
    check(aeN == 1'b0, "R7 loaded empty offset 100", aeN, 0);
    writeN(92);
    idle(4);
    check(afN == 1'b0, "R3 R8 loaded full offset 900", afN, 0);

    // serial load
    loadSer(5, 10);
    readBack(5,  "R4 serial empty offset");
    readBack(10, "R4 serial full offset");

    // asynchronous timing, parity skip, preset index 7 -> 1023
    doReset(1'b1, 1'b1, 1'b1, 2'b11);
    check(aeN == 1'b0, "R1 aeN after second reset", aeN, 0);
    check(afN == 1'b1, "R1 afN after second reset", afN, 1);
    check(dOut == '0,  "R1 dOut after second reset", dOut, 0);
    readBack(1023, "R1 preset 1023 empty");
    readBack(1023, "R1 preset 1023 full");
    loadPar(18'h00303);
    loadPar(18'h30014);
    readBack(259, "R6 parity bit skipped");
    readBack(20,  "R6 high bits ignored");

    loadPar(18'd2);
    loadPar(18'd3);
    writeN(2);
    check(aeN == 1'b0, "R11 occupancy equal to empty offset", aeN, 0);
    writeN(1);
    check(aeN == 1'b1, "R11 aeN cleared at write edge", aeN, 1);
    readN(1);
    check(aeN == 1'b0, "R11 aeN set at read edge", aeN, 0);
    writeN(1018);
    check(afN == 1'b1, "R11 free space 4", afN, 1);
    writeN(1);
    check(afN == 1'b0, "R11 afN set at write edge", afN, 0);
    readN(1);
    check(afN == 1'b1, "R11 afN cleared at read edge", afN, 1);

    idle(2);
    check(expQ.size() == 0, "R5 pending read-backs", expQ.size(), 0);
    finishRun();
  end

endmodule